// File: doc/BRIEF.md
# Five-Stage CIC Decimator with Gain Shift

This block reduces the sample rate of one signed real sample stream by an integer ratio between 1 and 32, using a cascade of five integrators and five combs. Integrators update on every accepted input sample. Combs update once per output sample, and each comb has a differential delay of one. The internal width is wide enough that the largest filter gain, 32 to the fifth power, never overflows. The ratio is set by a 5-bit code that holds the ratio minus one.

A right shift removes the filter gain. The result is then saturated to the input width. A code of zero gives rate 1 with no filtering, but the shift is still applied. A separate bypass input sends each input sample to the output unchanged, with no filtering and no shift.

The configuration inputs are expected to stay steady while samples stream. Whenever the decimation code changes, or bypass is active, the filter state and the sample counter are cleared. The next stream therefore starts from a known state.

Top module: `cic_decim5`

## Requirements
- R1: With decimation code c (ratio M = c+1) and bypass low, exactly one output strobe follows every M accepted input samples. It appears in the cycle after the M-th sample, so out_valid rises one clock after the in_valid cycle that completes the group.
- R2: Before scaling, each output equals the five-stage CIC response at that decimation instant: the sum over j of h[j]·x[n−j]. Here h is the coefficient set of (1+z⁻¹+…+z^−(M−1))⁵, x is the accepted input sequence since the last clear (zero before it), and n is the index of the M-th sample of the group.
- R3: With code 0 and bypass low, every accepted sample gives an output one cycle later. That output equals the input arithmetically shifted right by the scale value, with no filtering.
- R4: With bypass high, every input sample gives an output one cycle later that equals the input bit for bit. The decimation code and the scale value have no effect.
- R5: Scaling is an arithmetic right shift (rounding toward minus infinity) by the 5-bit scale value. Any value above 20 acts as 20.
- R6: A shifted result above 2^(W−1)−1 gives 2^(W−1)−1, and one below −2^(W−1) gives −2^(W−1), where W is the sample width.
- R7: In any cycle where dec_code differs from its value in the previous cycle, an input sample is dropped and produces no output. The integrators, combs and sample counter are cleared. They are held clear while bypass is high. A stream that follows starts from zero state.
- R8: During reset and after its release, out_valid is 0 and out_data is 0 until the first output. out_valid is never high unless in_valid was high in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | DW (16) | Signed input sample |
| dec_code | input | 5 | Decimation ratio minus one |
| scale_sh | input | 5 | Right shift amount, clamped to 20 |
| bypass | input | 1 | Pass input straight to output |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | DW (16) | Signed, scaled, saturated output sample |

## Verification
A corrupted integrator or comb register stays in the cascade. It shows up as a wrong value on the first output of the group in which it happened, and because the integrators never forget, it also affects every later output until the next clear. A sample counter that is off by one moves the output strobe by a whole input sample. That changes both the number of outputs in a stream and every value after the error. Faults in the shift or the saturation appear on the very next output strobe. The saturation cases are driven with constant full-scale input at ratio 32 with no shift.

// File: rtl/cic_pkg.sv
package cic_pkg;
  localparam int CIC_STAGES = 5;
  localparam int CIC_CODE_W = 5;
  localparam int CIC_SHIFT_W = 5;
  localparam int CIC_SHIFT_MAX = 20;
endpackage

// File: rtl/cic_integ.sv
module cic_integ #(
  parameter int W = 41,
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         clr,
  input  logic [W-1:0] x,
  output logic [W-1:0] y
);
  logic [W-1:0] acc_q [N];
  logic [W-1:0] sum   [N];

  generate
    for (genvar k = 0; k < N; k++) begin : g_stage
      if (k == 0) begin : g_first
        always_comb sum[k] = acc_q[k] + x;
      end else begin : g_rest
        always_comb sum[k] = acc_q[k] + sum[k-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          acc_q[k] <= '0;
        end else if (clr) begin
          acc_q[k] <= '0;
        end else if (en) begin
          acc_q[k] <= sum[k];
        end
      end
    end
  endgenerate

  assign y = sum[N-1];
endmodule

// File: rtl/cic_comb.sv
module cic_comb #(
  parameter int W = 41,
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         clr,
  input  logic [W-1:0] x,
  output logic [W-1:0] y
);
  logic [W-1:0] dly_q [N];
  logic [W-1:0] stg_in [N];
  logic [W-1:0] diff [N];

  generate
    for (genvar k = 0; k < N; k++) begin : g_stage
      if (k == 0) begin : g_first
        always_comb stg_in[k] = x;
      end else begin : g_rest
        always_comb stg_in[k] = diff[k-1];
      end
      always_comb diff[k] = stg_in[k] - dly_q[k];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          dly_q[k] <= '0;
        end else if (clr) begin
          dly_q[k] <= '0;
        end else if (en) begin
          dly_q[k] <= stg_in[k];
        end
      end
    end
  endgenerate

  assign y = diff[N-1];
endmodule

// File: rtl/cic_scale.sv
module cic_scale #(
  parameter int AW = 41,
  parameter int DW = 16,
  parameter int SW = 5,
  parameter int SMAX = 20
) (
  input  logic [AW-1:0] v,
  input  logic [SW-1:0] sh,
  output logic [DW-1:0] q
);
  localparam logic signed [AW-1:0] OMAX = {{(AW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [AW-1:0] OMIN = {{(AW-DW+1){1'b1}}, {(DW-1){1'b0}}};

  logic [SW-1:0]        sh_eff;
  logic signed [AW-1:0] shifted;

  always_comb begin
    sh_eff  = (sh > SW'(SMAX)) ? SW'(SMAX) : sh;
    shifted = $signed(v) >>> sh_eff;
    if (shifted > OMAX) begin
      q = OMAX[DW-1:0];
    end else if (shifted < OMIN) begin
      q = OMIN[DW-1:0];
    end else begin
      q = shifted[DW-1:0];
    end
  end
endmodule

// File: rtl/cic_decim5.sv
module cic_decim5 #(
  parameter int DW   = 16,
  parameter int NSTG = cic_pkg::CIC_STAGES,
  parameter int CW   = cic_pkg::CIC_CODE_W,
  parameter int SW   = cic_pkg::CIC_SHIFT_W,
  parameter int SMAX = cic_pkg::CIC_SHIFT_MAX
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic [CW-1:0] dec_code,
  input  logic [SW-1:0] scale_sh,
  input  logic          bypass,
  output logic          out_valid,
  output logic [DW-1:0] out_data
);
  localparam int AW = DW + NSTG * CW;

  logic          rst_meta_q, rst_q;
  logic [CW-1:0] code_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          clear, take, last;
  logic [AW-1:0] x_ext, integ_y, comb_y, filt_src;
  logic [DW-1:0] scaled;
  logic          vld_d;
  logic [DW-1:0] dat_d;

  // reset: asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_q      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q      <= rst_meta_q;
    end
  end

  assign clear = (dec_code != code_q) || bypass;
  assign take  = in_valid && !clear;
  assign last  = (cnt_q == dec_code);
  assign x_ext = {{(AW-DW){in_data[DW-1]}}, in_data};

  always_comb begin
    cnt_d = cnt_q;
    if (clear) begin
      cnt_d = '0;
    end else if (take) begin
      cnt_d = last ? '0 : cnt_q + 1'b1;
    end
  end

  cic_integ #(.W(AW), .N(NSTG)) i_integ (
    .clk(clk), .rst_n(rst_q), .en(take), .clr(clear), .x(x_ext), .y(integ_y)
  );

  cic_comb #(.W(AW), .N(NSTG)) i_comb (
    .clk(clk), .rst_n(rst_q), .en(take && last), .clr(clear), .x(integ_y), .y(comb_y)
  );

  assign filt_src = (dec_code == '0) ? x_ext : comb_y;

  cic_scale #(.AW(AW), .DW(DW), .SW(SW), .SMAX(SMAX)) i_scale (
    .v(filt_src), .sh(scale_sh), .q(scaled)
  );

  always_comb begin
    vld_d = 1'b0;
    dat_d = out_data;
    if (in_valid && bypass) begin
      vld_d = 1'b1;
      dat_d = in_data;
    end else if (take && last) begin
      vld_d = 1'b1;
      dat_d = scaled;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      code_q    <= '0;
      cnt_q     <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      code_q    <= dec_code;
      cnt_q     <= cnt_d;
      out_valid <= vld_d;
      out_data  <= dat_d;
    end
  end

  assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_q)
    cnt_q <= code_q);

  assert_rate_one_R3: assert property (@(posedge clk) disable iff (!rst_q)
    (in_valid && !bypass && dec_code == '0 && code_q == '0) |=> out_valid);

  assert_bypass_exact_R4: assert property (@(posedge clk) disable iff (!rst_q)
    (in_valid && bypass) |=> (out_valid && out_data == $past(in_data)));

  assert_drop_on_change_R7: assert property (@(posedge clk) disable iff (!rst_q)
    (in_valid && !bypass && dec_code != code_q) |=> !out_valid);

  assert_out_follows_in_R8: assert property (@(posedge clk) disable iff (!rst_q)
    out_valid |-> $past(in_valid));
endmodule

// File: tb/test_cic_decim5.sv
module test_cic_decim5;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic [4:0]    dec_code = '0;
  logic [4:0]    scale_sh = '0;
  logic          bypass = 1'b0;
  logic          out_valid;
  logic [DW-1:0] out_data;

  int total = 0;
  int bad = 0;
  int nobs = 0;
  int unsigned seed = 32'd12345;
  logic [DW-1:0] obs [512];
  longint xs [512];
  longint h [200];
  int prev_code = 0;

  cic_decim5 i_cic_decim5 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .dec_code(dec_code), .scale_sh(scale_sh), .bypass(bypass),
    .out_valid(out_valid), .out_data(out_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (rst_n && out_valid && nobs < 512) begin
      obs[nobs] = out_data;
      nobs = nobs + 1;
    end
  end

  task automatic check(input string tag, input longint act, input longint exp);
    total = total + 1;
    if (act != exp) begin
      bad = bad + 1;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int build_h(input int m);
    longint t [200];
    int len = 1;
    h[0] = 1;
    for (int s = 0; s < 5; s++) begin
      for (int i = 0; i < len + m - 1; i++) t[i] = 0;
      for (int i = 0; i < len; i++)
        for (int j = 0; j < m; j++) t[i+j] = t[i+j] + h[i];
      len = len + m - 1;
      for (int i = 0; i < len; i++) h[i] = t[i];
    end
    return len;
  endfunction

  function automatic longint scale_sat(input longint v, input int sh);
    longint r;
    int s = (sh > 20) ? 20 : sh;
    r = v >>> s;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  // kind: 0 random, 1 full positive, 2 full negative
  task automatic segment(input int code, input int sh, input bit byp, input int ns,
                         input int kind, input string tag);
    int m = code + 1;
    int len;
    int k = 0;
    int nexp = 0;
    longint acc;
    @(negedge clk);
    in_valid = 1'b0;
    if (code == prev_code && !byp) begin
      bypass = 1'b1;
      @(negedge clk);
    end
    dec_code = 5'(code);
    scale_sh = 5'(sh);
    bypass = byp;
    prev_code = code;
    repeat (2) @(negedge clk);
    nobs = 0;
    while (k < ns) begin
      if (($urandom(seed) % 3) != 0) begin
        if (kind == 1) xs[k] = 32767;
        else if (kind == 2) xs[k] = -32768;
        else xs[k] = longint'($signed(16'($urandom(seed))));
        in_valid = 1'b1;
        in_data = 16'(xs[k]);
        k = k + 1;
      end else begin
        in_valid = 1'b0;
        in_data = 16'($urandom(seed));
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    len = build_h(m);
    for (int n = 0; n < ns; n++) begin
      if (byp) begin
        if (nexp < nobs) check({tag, " bypass value"}, longint'($signed(obs[nexp])), xs[n]);
        nexp = nexp + 1;
      end else if ((n + 1) % m == 0) begin
        acc = 0;
        for (int j = 0; j < len && j <= n; j++) acc = acc + h[j] * xs[n-j];
        if (nexp < nobs) check({tag, " value"}, longint'($signed(obs[nexp])), scale_sat(acc, sh));
        nexp = nexp + 1;
      end
    end
    check({tag, " R1 output count"}, nobs, nexp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset out_valid", out_valid, 0);
    check("R8 reset out_data", out_data, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R8 idle after reset", out_valid, 0);

    segment(3, 10, 0, 40, 0, "R1 R2 ratio4");
    segment(31, 25, 0, 200, 0, "R5 R2 ratio32 clamp");
    segment(0, 3, 0, 30, 0, "R3 code0 shift");
    segment(5, 7, 1, 30, 0, "R4 bypass");
    segment(31, 0, 0, 96, 1, "R6 sat high");
    segment(31, 0, 0, 96, 2, "R6 sat low");
    segment(2, 4, 0, 13, 0, "R7 partial");
    segment(6, 8, 0, 50, 0, "R7 after change");
    segment(7, 15, 0, 64, 0, "R2 R5 ratio8");
    segment(1, 0, 0, 40, 0, "R2 ratio2");

    // R7: sample presented in the cycle the code changes is dropped
    @(negedge clk);
    nobs = 0;
    dec_code = 5'd0;
    scale_sh = 5'd0;
    bypass = 1'b0;
    in_valid = 1'b1;
    in_data = 16'd123;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    check("R7 dropped on change", nobs, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad = bad + 1;
    total = total + 1;
    $display("FAIL watchdog R1 actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule